// File: doc/BRIEF.md
# Dual-Granularity SPI Serial Clock Generator

This block derives the serial clock of one SPI channel from a fixed reference clock (48 MHz in the intended system, which is also the fastest serial clock it can give). A granularity select picks one of two ways to read the divider fields. In power-of-two mode the 4-bit low field alone gives a ratio of 2 to the power of that field. In unit-step mode the 4-bit low field and an 8-bit extension field are joined, with the extension field as the upper bits, and one is added. This gives any integer ratio from 1 to 4096.

The shift logic next to it does not look at the serial clock. It uses single reference-cycle strobes that mark the edge leaving idle level and the edge returning to idle level. It also uses a sample strobe and a shift strobe, which the phase select routes from those two. Polarity sets the idle level. Ratio and mode changes are held back until the current serial clock period has finished. While the channel is disabled the clock rests at idle and the divider is held cleared.

Top module: `spiclk_gen`

## Requirements
- R1: While reset is asserted, and on every cycle after a clock edge at which `chan_en` was low, `sclk` equals `cpol` and all four strobes are 0.
- R2: With `fine_gran`=0 the period of `sclk` is 2**`div_lo` reference cycles.
- R3: With `fine_gran`=1 the period is `div_ext`*16 + `div_lo` + 1 reference cycles.
- R4: For a ratio N of at least 2, each period opens with ceil(N/2) cycles at the active level (not `cpol`), followed by floor(N/2) cycles at the idle level. An odd N therefore gives a longer active half.
- R5: A ratio of 1 passes the reference clock through: `sclk` equals `clk_ref` XOR `cpol`, and both edge strobes are 1 on every cycle.
- R6: `lead_stb` is 1 exactly in the first cycle of each active half. `trail_stb` is 1 exactly in the first cycle of each idle half.
- R7: Setting `cpol` to 1 inverts both the idle level and the active level of `sclk`.
- R8: With `cpha`=0, `sample_stb` follows `lead_stb` and `shift_stb` follows `trail_stb`. With `cpha`=1 the two roles swap.
- R9: A change of `div_lo`, `div_ext` or `fine_gran` during a period does not affect that period. It first applies to the period that follows.
- R10: The first clock edge at which `chan_en` is high after a low spell starts a fresh period. That cycle is the first cycle of an active half and uses the divider inputs present at that edge.
- R11: The largest unit-step ratio (`div_ext`=255, `div_lo`=15) gives a period of 4096 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel enable |
| div_lo | input | 4 | Low divider field |
| div_ext | input | 8 | Extension divider field (upper ratio bits in unit-step mode) |
| fine_gran | input | 1 | 0 selects power-of-two mode, 1 selects unit-step mode |
| cpol | input | 1 | Idle level of sclk |
| cpha | input | 1 | 0 samples on the leading edge, 1 samples on the trailing edge |
| sclk | output | 1 | Serial clock |
| lead_stb | output | 1 | Pulse on the idle-to-active transition |
| trail_stb | output | 1 | Pulse on the active-to-idle transition |
| sample_stb | output | 1 | Strobe for the edge on which data is sampled |
| shift_stb | output | 1 | Strobe for the edge on which data is launched |

## Verification
The bench targets ratios where an off-by-one would show at once. At ratio 2 a half that is one cycle wrong would break the strict lead/trail alternation. At the odd ratio 5 a swapped rounding would put the longer half on the idle side. At the bypass ratio 1 a counter-based clock would stop toggling instead of following the reference. It changes the divider in mid-period and checks that the running period keeps its old length, which a design that reloads at once would cut short. It also checks that the largest extension value reaches the full 4096-cycle ratio rather than wrapping, and that a disable in mid-period drops cleanly to idle and later restarts with a full active half.

// File: rtl/spiclk_pkg.sv
package spiclk_pkg;

   typedef enum logic {
      GRAN_POW2 = 1'b0,
      GRAN_UNIT = 1'b1
   } gran_e;

   function automatic int ratio_width(input int lo_w, input int ext_w);
      int pow_bits;
      pow_bits = (1 << lo_w);
      return (pow_bits > lo_w + ext_w + 1) ? pow_bits : lo_w + ext_w + 1;
   endfunction

endpackage

// File: rtl/spiclk_ratio.sv
module spiclk_ratio
   import spiclk_pkg::*;
#(
   parameter int LO_W    = 4,
   parameter int EXT_W   = 8,
   parameter int RATIO_W = 16
) (
   input  logic [LO_W-1:0]    div_lo,
   input  logic [EXT_W-1:0]   div_ext,
   input  gran_e              gran,
   output logic [RATIO_W-1:0] ratio
);

   localparam int JOIN_W = LO_W + EXT_W;

   logic [JOIN_W-1:0] joined;

   assign joined = {div_ext, div_lo};

   always_comb begin
      if (gran == GRAN_UNIT) begin
         ratio = RATIO_W'(joined) + RATIO_W'(1);
      end else begin
         ratio = RATIO_W'(1) << div_lo;
      end
   end

endmodule

// File: rtl/spiclk_phase_ctr.sv
module spiclk_phase_ctr #(
   parameter int RATIO_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic [RATIO_W-1:0] next_ratio,
   output logic               running,
   output logic               active,
   output logic               bypass,
   output logic               lead,
   output logic               trail
);

   logic               run_q;
   logic               idle_half_q;
   logic [RATIO_W-1:0] cnt_q;
   logic [RATIO_W-1:0] cur_q;
   logic [RATIO_W-1:0] half_hi;
   logic [RATIO_W-1:0] half_lo;
   logic               is_unit;
   logic               cnt_zero;

   assign half_lo  = cur_q >> 1;
   assign half_hi  = cur_q - half_lo;
   assign is_unit  = (cur_q == RATIO_W'(1));
   assign cnt_zero = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q       <= 1'b0;
         idle_half_q <= 1'b0;
         cnt_q       <= '0;
         cur_q       <= RATIO_W'(1);
      end else if (!en) begin
         run_q       <= 1'b0;
         idle_half_q <= 1'b0;
         cnt_q       <= '0;
         cur_q       <= next_ratio;
      end else if (!run_q) begin
         run_q       <= 1'b1;
         idle_half_q <= 1'b0;
         cnt_q       <= '0;
         cur_q       <= next_ratio;
      end else if (is_unit) begin
         cur_q <= next_ratio;
      end else if (!idle_half_q) begin
         if (cnt_q == half_hi - RATIO_W'(1)) begin
            idle_half_q <= 1'b1;
            cnt_q       <= '0;
         end else begin
            cnt_q <= cnt_q + RATIO_W'(1);
         end
      end else begin
         if (cnt_q == half_lo - RATIO_W'(1)) begin
            idle_half_q <= 1'b0;
            cnt_q       <= '0;
            cur_q       <= next_ratio;
         end else begin
            cnt_q <= cnt_q + RATIO_W'(1);
         end
      end
   end

   assign running = run_q;
   assign bypass  = run_q & is_unit;
   assign active  = run_q & ~idle_half_q;
   assign lead    = run_q & ~idle_half_q & cnt_zero;
   assign trail   = run_q & ((idle_half_q & cnt_zero) | is_unit);

   // R9: the ratio in use is frozen except at a period boundary
   assert_ratio_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && en && !is_unit && !(idle_half_q && cnt_q == half_lo - RATIO_W'(1)))
         |=> $stable(cur_q));

   // R4: active half never outlasts ceil(N/2)
   assert_active_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !idle_half_q) |-> (cnt_q < half_hi));

   // R4: idle half never outlasts floor(N/2)
   assert_idle_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && idle_half_q) |-> (cnt_q < half_lo));

endmodule

// File: rtl/spiclk_gen.sv
module spiclk_gen
   import spiclk_pkg::*;
#(
   parameter int LO_W  = 4,
   parameter int EXT_W = 8
) (
   input  logic             clk_ref,
   input  logic             rst_n,
   input  logic             chan_en,
   input  logic [LO_W-1:0]  div_lo,
   input  logic [EXT_W-1:0] div_ext,
   input  logic             fine_gran,
   input  logic             cpol,
   input  logic             cpha,
   output logic             sclk,
   output logic             lead_stb,
   output logic             trail_stb,
   output logic             sample_stb,
   output logic             shift_stb
);

   localparam int RATIO_W = ratio_width(LO_W, EXT_W);

   generate
      if (LO_W < 1 || LO_W > 5) begin : g_bad_lo
         $error("spiclk_gen: LO_W must lie in 1..5");
      end
      if (EXT_W < 1) begin : g_bad_ext
         $error("spiclk_gen: EXT_W must be at least 1");
      end
   endgenerate

   logic [RATIO_W-1:0] next_ratio;
   logic               running;
   logic               active;
   logic               bypass;
   logic               lead;
   logic               trail;
   gran_e              gran;

   assign gran = gran_e'(fine_gran);

   spiclk_ratio #(
      .LO_W    (LO_W),
      .EXT_W   (EXT_W),
      .RATIO_W (RATIO_W)
   ) u_ratio (
      .div_lo  (div_lo),
      .div_ext (div_ext),
      .gran    (gran),
      .ratio   (next_ratio)
   );

   spiclk_phase_ctr #(
      .RATIO_W (RATIO_W)
   ) u_ctr (
      .clk        (clk_ref),
      .rst_n      (rst_n),
      .en         (chan_en),
      .next_ratio (next_ratio),
      .running    (running),
      .active     (active),
      .bypass     (bypass),
      .lead       (lead),
      .trail      (trail)
   );

   assign sclk       = bypass ? (clk_ref ^ cpol) : (active ^ cpol);
   assign lead_stb   = lead;
   assign trail_stb  = trail;
   assign sample_stb = cpha ? trail : lead;
   assign shift_stb  = cpha ? lead : trail;

   // R1: a disabled channel is quiet at the idle level
   assert_off_quiet_R1: assert property (@(posedge clk_ref) disable iff (!rst_n)
      !chan_en |=> (!lead_stb && !trail_stb && sclk == cpol && !running));

   // R6: outside bypass, a leading strobe never repeats on the next cycle
   assert_lead_single_R6: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (lead_stb && !trail_stb) |=> !lead_stb);

   // R8: each role strobe marks one of the two edges
   assert_role_edge_R8: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (sample_stb || shift_stb) |-> (lead_stb || trail_stb));

endmodule

// File: tb/spiclk_gen_tb.sv
module spiclk_gen_tb;

   localparam int CLK_P = 10;

   logic       clk_ref = 1'b0;
   logic       rst_n   = 1'b0;
   logic       chan_en = 1'b0;
   logic [3:0] div_lo  = 4'd0;
   logic [7:0] div_ext = 8'd0;
   logic       fine_gran = 1'b0;
   logic       cpol = 1'b0;
   logic       cpha = 1'b0;
   logic       sclk, lead_stb, trail_stb, sample_stb, shift_stb;

   int checks = 0;
   int errors = 0;

   logic [4:0] exp_q[$];
   string      tag_q[$];

   always #(CLK_P/2) clk_ref = ~clk_ref;

   spiclk_gen u_dut (
      .clk_ref    (clk_ref),
      .rst_n      (rst_n),
      .chan_en    (chan_en),
      .div_lo     (div_lo),
      .div_ext    (div_ext),
      .fine_gran  (fine_gran),
      .cpol       (cpol),
      .cpha       (cpha),
      .sclk       (sclk),
      .lead_stb   (lead_stb),
      .trail_stb  (trail_stb),
      .sample_stb (sample_stb),
      .shift_stb  (shift_stb)
   );

   function automatic logic [4:0] mk_item(input logic act, input logic ld, input logic tr,
                                          input logic pol, input logic pha);
      return {act ^ pol, ld, tr, pha ? tr : ld, pha ? ld : tr};
   endfunction

   // push the first `count` cycles of one period of ratio n
   task automatic push_period(input int n, input logic pol, input logic pha,
                              input string tag, input int count);
      int hi;
      hi = (n + 1) / 2;
      for (int i = 0; i < count; i++) begin
         if (n == 1) exp_q.push_back(mk_item(1'b1, 1'b1, 1'b1, pol, pha));
         else exp_q.push_back(mk_item(i < hi, i == 0, i == hi, pol, pha));
         tag_q.push_back(tag);
      end
   endtask

   task automatic push_idle(input logic pol, input string tag, input int count);
      for (int i = 0; i < count; i++) begin
         exp_q.push_back({pol, 4'b0000});
         tag_q.push_back(tag);
      end
   endtask

   task automatic drain();
      wait (exp_q.size() == 0);
   endtask

   task automatic stop_channel(input string tag);
      @(negedge clk_ref);
      chan_en = 1'b0;
      push_idle(cpol, tag, 2);
      drain();
   endtask

   task automatic run_case(input logic [3:0] lo, input logic [7:0] ext, input logic fine,
                           input logic pol, input logic pha, input int n, input int periods,
                           input string tag);
      @(negedge clk_ref);
      div_lo = lo; div_ext = ext; fine_gran = fine; cpol = pol; cpha = pha;
      @(negedge clk_ref);
      chan_en = 1'b1;
      for (int p = 0; p < periods; p++) push_period(n, pol, pha, tag, n);
      drain();
      stop_channel("R1 idle after disable");
   endtask

   task automatic direct_check(input string tag);
      checks++;
      if ({sclk, lead_stb, trail_stb, sample_stb, shift_stb} !== {cpol, 4'b0000}) begin
         errors++;
         $display("FAIL %s act=%b exp=%b", tag,
                  {sclk, lead_stb, trail_stb, sample_stb, shift_stb}, {cpol, 4'b0000});
      end
   endtask

   // monitor: one expected item per cycle, sampled while clk_ref is high
   initial begin
      logic [4:0] e;
      logic [4:0] a;
      string      t;
      forever begin
         @(posedge clk_ref);
         #(CLK_P/4);
         if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = {sclk, lead_stb, trail_stb, sample_stb, shift_stb};
            checks++;
            if (a !== e) begin
               errors++;
               $display("FAIL %s act=%b exp=%b", t, a, e);
            end
         end
      end
   end

   initial begin
      #(CLK_P * 200000);
      checks++;
      errors++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // R1: outputs during reset, both polarities
      #(CLK_P * 2 + 1);
      direct_check("R1 reset cpol0");
      cpol = 1'b1;
      #1;
      direct_check("R1 reset cpol1");
      cpol = 1'b0;
      @(negedge clk_ref);
      rst_n = 1'b1;

      // R2: power-of-two ratio 4
      run_case(4'd2, 8'd0, 1'b0, 1'b0, 1'b0, 4, 3, "R2 pow2 ratio4");
      // R2: power-of-two ratio 16, extension field ignored
      run_case(4'd4, 8'd9, 1'b0, 1'b0, 1'b0, 16, 2, "R2 pow2 ratio16");
      // R5: ratio 1 pass-through, sampled with clk_ref high
      run_case(4'd0, 8'd0, 1'b0, 1'b0, 1'b0, 1, 5, "R5 bypass");
      run_case(4'd0, 8'd0, 1'b1, 1'b1, 1'b1, 1, 4, "R5 R7 bypass inverted");
      // R4 R7 R8: odd ratio 5 with inverted polarity and trailing sample
      run_case(4'd4, 8'd0, 1'b1, 1'b1, 1'b1, 5, 3, "R4 R7 R8 odd ratio5");
      // R8: leading sample with inverted polarity, ratio 6
      run_case(4'd5, 8'd0, 1'b1, 1'b1, 1'b0, 6, 2, "R8 cpha0 ratio6");
      // R3: extension field contributes upper bits: 2*16+3+1 = 36
      run_case(4'd3, 8'd2, 1'b1, 1'b0, 1'b1, 36, 2, "R3 unit ratio36");
      // R6: ratio 2 strict alternation of strobes
      run_case(4'd1, 8'd0, 1'b0, 1'b0, 1'b0, 2, 4, "R6 ratio2");
      // R11: largest unit-step ratio
      run_case(4'd15, 8'd255, 1'b1, 1'b0, 1'b0, 4096, 1, "R11 ratio4096");

      // R9: change ratio 4 -> 6 in mid-period
      @(negedge clk_ref);
      div_lo = 4'd3; div_ext = 8'd0; fine_gran = 1'b1; cpol = 1'b0; cpha = 1'b0;
      @(negedge clk_ref);
      chan_en = 1'b1;
      push_period(4, 1'b0, 1'b0, "R9 old ratio kept", 4);
      push_period(6, 1'b0, 1'b0, "R9 new ratio", 6);
      push_period(6, 1'b0, 1'b0, "R9 new ratio", 6);
      @(posedge clk_ref);
      @(negedge clk_ref);
      div_lo = 4'd5;
      drain();
      stop_channel("R1 idle after R9");

      // R10: disable mid-period, then restart with a full fresh period
      @(negedge clk_ref);
      div_lo = 4'd3; fine_gran = 1'b0;
      @(negedge clk_ref);
      chan_en = 1'b1;
      push_period(8, 1'b0, 1'b0, "R10 partial", 3);
      drain();
      @(negedge clk_ref);
      chan_en = 1'b0;
      push_idle(1'b0, "R10 drop to idle", 2);
      drain();
      @(negedge clk_ref);
      chan_en = 1'b1;
      push_period(8, 1'b0, 1'b0, "R10 restart", 8);
      drain();
      stop_channel("R1 idle at end");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule